// File: doc/BRIEF.md
# Time-Division Multiplexed Frame Serializer

This block merges a set of parallel channel bytes onto a single serial line. The line is divided into repeating frames, and each frame holds one time slot per channel. A free-running position counter walks the slots in ascending channel order, so every channel reappears at the same place in each frame. A `slot_idx` output reports which channel owns the bit on the line, and `frame_start` marks the first bit of every frame so that a receiver can align to it.

There are two interleaving modes. In bit-interleaved mode each slot lasts one clock and carries one bit of its channel's byte. Successive frames carry successive bits, starting at the most significant, so a whole byte crosses the line in eight frames. In word-interleaved mode each slot lasts one byte time and carries the full byte of its channel, most significant bit first. The mode is sampled only at the start of a frame, so a frame never mixes the two slot lengths.

A channel byte is captured from the parallel inputs on the clock edge that sends the first bit of its slot. Upstream logic can therefore update a channel's input at any time, and a change made part-way through a slot takes effect only at that channel's next slot.

Top module: `tdm_framer`

## Requirements
- R1: While `rst_n` is low, `ser_out`, `frame_start` and `slot_idx` are all 0. The first rising clock edge after release sends the first bit of slot 0, and `frame_start` is 1 at that bit.
- R2: `slot_idx` runs 0, 1, ..., NUM_CH-1 in steps of one and then wraps to 0. It never reaches NUM_CH, and channel c occupies slot c in every frame.
- R3: `frame_start` is 1 for exactly one clock per frame: on the first bit of slot 0 and at no other time.
- R4: With `mode_word`=0 (bit-interleaved), each slot lasts one clock. In frame k, counted from 0 since reset and including frames sent in the other mode, slot c carries bit (7 - k mod 8) of channel c.
- R5: With `mode_word`=1 (word-interleaved), each slot lasts WORD_W clocks and carries channel c's byte, most significant bit first. Channel c is bits [8c+7:8c] of `ch_data`.
- R6: A channel byte is sampled on the clock edge that sends its slot's first bit. Changes to that channel's input later in the same slot do not alter the bits sent in that slot.
- R7: `mode_word` is sampled only on the edge that sends the first bit of a frame. A change made during a frame has no effect until the next frame starts.
- R8: Asserting `rst_n` in the middle of a frame clears the outputs at once. After release, the serializer restarts at slot 0 with frame count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mode_word | input | 1 | 0: one bit per slot; 1: one byte per slot |
| ch_data | input | NUM_CH*WORD_W | Channel bytes, channel c in bits [WORD_W*c+WORD_W-1 : WORD_W*c] |
| ser_out | output | 1 | Serial line |
| slot_idx | output | $clog2(NUM_CH) | Channel owning the current bit |
| frame_start | output | 1 | High on the first bit of each frame |

## Verification
Three events can fall on the same edge: the wrap from the last slot to slot 0, the advance of the bit-mode frame phase, and the sampling of a new mode. The bench provokes this by changing `mode_word` at the sample point of the final slot, so the new value meets the wrap edge directly. It then judges the result in two ways. The next frame must come out entirely in the new mode. A later bit-mode frame must pick the bit index given by the total frame count, which confirms the phase advanced during the word frame in between. A second collision is also covered: a channel's input is inverted in the middle of its own word slot, and the bench checks that the captured byte still goes out unchanged in that slot, while the following frame carries the new value.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

  typedef enum logic {
    MODE_BIT  = 1'b0,
    MODE_WORD = 1'b1
  } tdm_mode_e;

endpackage

// File: rtl/tdm_slot_seq.sv
module tdm_slot_seq
  import tdm_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int WORD_W = 8,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_req,
  output logic [SLOT_W-1:0] slot_cnt,
  output logic [BIT_W-1:0]  bit_cnt,
  output logic [BIT_W-1:0]  phase,
  output tdm_mode_e         mode_eff,
  output logic              head
);

  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(NUM_CH - 1);
  localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(WORD_W - 1);

  logic [SLOT_W-1:0] slot_q, slot_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BIT_W-1:0]  phase_q, phase_d;
  tdm_mode_e         mode_q, mode_d;
  logic              last_bit, last_slot;

  // Position counters point at the bit to be sent on the next edge.
  always_comb begin
    head      = (slot_q == '0) && (bit_q == '0);
    mode_eff  = head ? tdm_mode_e'(mode_req) : mode_q;
    last_bit  = (mode_eff == MODE_BIT) || (bit_q == LAST_BIT);
    last_slot = (slot_q == LAST_SLOT);

    slot_d  = slot_q;
    bit_d   = bit_q;
    phase_d = phase_q;
    mode_d  = mode_eff;

    if (last_bit) begin
      bit_d = '0;
      if (last_slot) begin
        slot_d  = '0;
        phase_d = (phase_q == LAST_BIT) ? '0 : phase_q + BIT_W'(1);
      end else begin
        slot_d = slot_q + SLOT_W'(1);
      end
    end else begin
      bit_d = bit_q + BIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q  <= '0;
      bit_q   <= '0;
      phase_q <= '0;
      mode_q  <= MODE_BIT;
    end else begin
      slot_q  <= slot_d;
      bit_q   <= bit_d;
      phase_q <= phase_d;
      mode_q  <= mode_d;
    end
  end

  assign slot_cnt = slot_q;
  assign bit_cnt  = bit_q;
  assign phase    = phase_q;

endmodule

// File: rtl/tdm_chan_sel.sv
module tdm_chan_sel
  import tdm_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int WORD_W = 8,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic [NUM_CH*WORD_W-1:0] ch_data,
  input  logic [SLOT_W-1:0]        slot_cnt,
  input  logic [BIT_W-1:0]         phase,
  input  tdm_mode_e                mode_eff,
  output logic [WORD_W-1:0]        load_val
);

  logic [WORD_W-1:0] lane [NUM_CH];
  logic [WORD_W-1:0] picked;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    assign lane[g] = ch_data[g*WORD_W +: WORD_W];
  end

  always_comb begin
    picked = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (slot_cnt == SLOT_W'(c)) picked = lane[c];
    end
  end

  // In bit mode the wanted bit is moved to the MSB so one shifter serves both modes.
  always_comb begin
    if (mode_eff == MODE_WORD) load_val = picked;
    else                       load_val = picked << phase;
  end

endmodule

// File: rtl/tdm_shift_out.sv
module tdm_shift_out #(
  parameter int NUM_CH = 24,
  parameter int WORD_W = 8,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [WORD_W-1:0] load_val,
  input  logic [SLOT_W-1:0] slot_in,
  input  logic              head_in,
  output logic              ser_out,
  output logic [SLOT_W-1:0] slot_idx,
  output logic              frame_start
);

  logic [WORD_W-1:0] shreg_q, shreg_d;
  logic [SLOT_W-1:0] slot_q;
  logic              fs_q;

  always_comb begin
    if (load_en) shreg_d = load_val;
    else         shreg_d = shreg_q << 1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      slot_q  <= '0;
      fs_q    <= 1'b0;
    end else begin
      shreg_q <= shreg_d;
      slot_q  <= slot_in;
      fs_q    <= head_in;
    end
  end

  assign ser_out     = shreg_q[WORD_W-1];
  assign slot_idx    = slot_q;
  assign frame_start = fs_q;

endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
  import tdm_pkg::*;
#(
  parameter int NUM_CH = 24,
  parameter int WORD_W = 8,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int BIT_W  = (WORD_W > 1) ? $clog2(WORD_W) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mode_word,
  input  logic [NUM_CH*WORD_W-1:0] ch_data,
  output logic                     ser_out,
  output logic [SLOT_W-1:0]        slot_idx,
  output logic                     frame_start
);

  logic [SLOT_W-1:0] slot_cnt;
  logic [BIT_W-1:0]  bit_cnt;
  logic [BIT_W-1:0]  phase;
  tdm_mode_e         mode_eff;
  logic              head;
  logic              load_en;
  logic [WORD_W-1:0] load_val;

  tdm_slot_seq #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_req (mode_word),
    .slot_cnt (slot_cnt),
    .bit_cnt  (bit_cnt),
    .phase    (phase),
    .mode_eff (mode_eff),
    .head     (head)
  );

  tdm_chan_sel #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_sel (
    .ch_data  (ch_data),
    .slot_cnt (slot_cnt),
    .phase    (phase),
    .mode_eff (mode_eff),
    .load_val (load_val)
  );

  // Capture happens on the edge that sends a slot's first bit.
  assign load_en = (bit_cnt == '0);

  tdm_shift_out #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .load_en     (load_en),
    .load_val    (load_val),
    .slot_in     (slot_cnt),
    .head_in     (head),
    .ser_out     (ser_out),
    .slot_idx    (slot_idx),
    .frame_start (frame_start)
  );

endmodule

// File: rtl/tdm_framer_chk.sv
module tdm_framer_chk #(
  parameter int NUM_CH = 24,
  parameter int WORD_W = 8,
  localparam int SLOT_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int RUN_W  = $clog2(WORD_W + 2) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_out,
  input logic [SLOT_W-1:0] slot_idx,
  input logic              frame_start
);

  logic [SLOT_W-1:0] prev_slot_q;
  logic [RUN_W-1:0]  run_q;
  logic              valid_q;
  logic              slot_new;

  assign slot_new = (slot_idx != prev_slot_q) || frame_start;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_slot_q <= '0;
      run_q       <= '0;
      valid_q     <= 1'b0;
    end else begin
      prev_slot_q <= slot_idx;
      if (frame_start) valid_q <= 1'b1;
      if (slot_new) run_q <= RUN_W'(1);
      else if (run_q <= RUN_W'(WORD_W)) run_q <= run_q + RUN_W'(1);
    end
  end

  // R2
  slot_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_idx < SLOT_W'(NUM_CH));

  // R3
  fs_slot0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (slot_idx == '0));

  // R3
  fs_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);

  // R2
  slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && (slot_idx != prev_slot_q)) |->
      ((slot_idx == prev_slot_q + SLOT_W'(1)) ||
       ((prev_slot_q == SLOT_W'(NUM_CH - 1)) && (slot_idx == '0))));

  // R4 R5
  slot_dwell_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_q && (slot_idx != prev_slot_q)) |->
      ((run_q == RUN_W'(1)) || (run_q == RUN_W'(WORD_W))));

endmodule

bind tdm_framer tdm_framer_chk #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ser_out     (ser_out),
  .slot_idx    (slot_idx),
  .frame_start (frame_start)
);

// File: tb/sim_tdm_framer.sv
module sim_tdm_framer;

  localparam int NCH = 24;
  localparam int WW  = 8;

  logic          clk;
  logic          rst_n;
  logic          mode_word;
  logic [NCH*WW-1:0] ch_data;
  logic          ser_out;
  logic [4:0]    slot_idx;
  logic          frame_start;

  logic [7:0] ch_drv [NCH];
  logic [7:0] exp_b  [NCH];

  int n_chk;
  int n_fail;
  int fr;
  int cyc;
  bit done;

  int hook_on, hook_s, hook_b, hook_kind, hook_val;

  tdm_framer #(.NUM_CH(NCH), .WORD_W(WW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_word   (mode_word),
    .ch_data     (ch_data),
    .ser_out     (ser_out),
    .slot_idx    (slot_idx),
    .frame_start (frame_start)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always_comb begin
    for (int c = 0; c < NCH; c++) ch_data[c*WW +: WW] = ch_drv[c];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
        finish_run();
      end
    end
  end

  task automatic load_pattern(input int seed);
    for (int c = 0; c < NCH; c++) begin
      ch_drv[c] = 8'((c * 37 + seed) ^ 8'hA5);
      exp_b[c]  = ch_drv[c];
    end
  endtask

  // Walk one frame from its first sample point; bit/word checks per R2..R5.
  task automatic do_frame(input bit wm, input string tag);
    logic [7:0] acc;
    int nb;
    nb = wm ? WW : 1;
    for (int s = 0; s < NCH; s++) begin
      acc = '0;
      for (int b = 0; b < nb; b++) begin
        chk(slot_idx == 5'(s), "R2 slot order", slot_idx, s);
        chk(frame_start == (s == 0 && b == 0), "R3 frame start", frame_start, (s == 0 && b == 0));
        if (wm) begin
          acc = {acc[6:0], ser_out};
          if (b == WW - 1)
            chk(acc == exp_b[s], tag, acc, exp_b[s]);
        end else begin
          chk(ser_out == exp_b[s][7 - (fr % 8)], tag, ser_out, exp_b[s][7 - (fr % 8)]);
        end
        if (hook_on != 0 && s == hook_s && b == hook_b) begin
          if (hook_kind == 1) mode_word = hook_val[0];
          else ch_drv[s] = ~ch_drv[s];
          hook_on = 0;
        end
        @(negedge clk);
      end
    end
    fr++;
  endtask

  task automatic set_hook(input int s, input int b, input int kind, input int val);
    hook_on = 1; hook_s = s; hook_b = b; hook_kind = kind; hook_val = val;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    mode_word = 1'b0;
    load_pattern(11);
    repeat (3) @(negedge clk);
    // R1: outputs held at zero in reset
    chk(ser_out == 1'b0, "R1 reset ser_out", ser_out, 0);
    chk(frame_start == 1'b0, "R1 reset frame_start", frame_start, 0);
    chk(slot_idx == 5'd0, "R1 reset slot_idx", slot_idx, 0);
    rst_n = 1'b1;
    @(negedge clk);
    fr = 0;
    chk(frame_start == 1'b1, "R1 first bit after release", frame_start, 1);
  endtask

  task automatic t_bit_mode();
    // R4: nine frames, phase wraps back to the MSB on the ninth
    for (int k = 0; k < 9; k++) do_frame(1'b0, "R4 bit mode");
  endtask

  task automatic t_mode_at_wrap();
    // R7: switch requested on the last slot meets the wrap edge
    set_hook(NCH - 1, 0, 1, 1);
    do_frame(1'b0, "R4 bit mode before switch");
    // R7: mid-frame request back to bit mode is ignored in this frame
    set_hook(5, 3, 1, 0);
    do_frame(1'b1, "R7 word frame kept despite mid-frame change");
    // R4: bit index follows total frame count, word frames included
    set_hook(NCH - 1, 0, 1, 1);
    do_frame(1'b0, "R4 phase after word frame");
  endtask

  task automatic t_latch();
    // R6: invert channel 7 after its slot has started
    set_hook(7, 2, 2, 0);
    do_frame(1'b1, "R6 captured byte held");
    exp_b[7] = ch_drv[7];
    do_frame(1'b1, "R6 new byte next frame");
  endtask

  task automatic t_reset_mid();
    repeat (50) @(negedge clk);
    rst_n = 1'b0;
    #1;
    // R8: asynchronous clear in mid frame
    chk(slot_idx == 5'd0, "R8 mid reset slot_idx", slot_idx, 0);
    chk(frame_start == 1'b0, "R8 mid reset frame_start", frame_start, 0);
    chk(ser_out == 1'b0, "R8 mid reset ser_out", ser_out, 0);
    mode_word = 1'b0;
    load_pattern(90);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    fr = 0;
    do_frame(1'b0, "R8 restart at frame 0");
    do_frame(1'b0, "R8 second frame after restart");
  endtask

  initial begin
    n_chk = 0; n_fail = 0; done = 0; hook_on = 0;
    hook_s = 0; hook_b = 0; hook_kind = 0; hook_val = 0;
    t_reset();
    t_bit_mode();
    t_mode_at_wrap();
    t_latch();
    t_reset_mid();
    finish_run();
  end

endmodule